// File: doc/BRIEF.md
# Nibble-Serial CRC-16 Engine

This block computes the 16-bit check value that protects the body of a serial-bus map or configuration header. Quadlets of 32 bits arrive over a valid/ready handshake. Each accepted quadlet is folded into the running check value four bits per clock, most significant nibble first, so every quadlet occupies the engine for eight cycles.

A start pulse clears the running value and aborts any run in progress. The quadlet flagged as last ends the run. The engine then raises a one-cycle done strobe and holds the result. It accepts no further data until the next start.

A small header former joins the held check value with a 16-bit upper field. That field is either the covered length of a topology map (entry count plus two) or the fixed speed-map tag. The check value covers only the quadlets after the header word, so the header itself is never fed through the engine.

Top module: `crc16n_engine`

## Requirements
- R1: After reset, `crc_o` is 0, `in_ready_o` is 1 and `done_o` is 0.
- R2: Each quadlet is split into eight nibbles, bits 31:28 first and bits 3:0 last. For every nibble, s = (crc[15:12] xor nibble) and the new value is ((crc << 4) xor (s << 12) xor (s << 5) xor s), kept to 16 bits.
- R3: The value carries across every quadlet of a run. It starts from 0 after a start pulse or reset and is not cleared between quadlets.
- R4: After every accepted quadlet, `in_ready_o` is low for exactly eight cycles. After a quadlet that is not last, it then returns high.
- R5: `done_o` is high for exactly one cycle: the cycle after the eighth nibble of the last quadlet. `crc_o` holds the final value in that cycle.
- R6: After `done_o`, `crc_o` stays unchanged and `in_ready_o` stays low until a start pulse.
- R7: A start pulse sets `crc_o` to 0 in the next cycle and returns the engine to the ready state. A run cut short this way, even in its final nibble cycle, produces no `done_o`.
- R8: When a start pulse and `in_valid_i` coincide while `in_ready_o` is high, the quadlet is taken as the first quadlet of the new run, starting from 0.
- R9: With `hdr_speed_i` = 0, `hdr_word_o` is {(`hdr_count_i` + 2) mod 65536, `crc_o`}, with the length in bits 31:16.
- R10: With `hdr_speed_i` = 1, `hdr_word_o` is {16'h03F1, `crc_o`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clears the check value and aborts a run |
| in_valid_i | input | 1 | Quadlet on `in_data_i` is valid |
| in_data_i | input | 32 | Quadlet to fold in |
| in_last_i | input | 1 | Marks the final quadlet of a run |
| in_ready_o | output | 1 | Engine can take a quadlet this cycle |
| done_o | output | 1 | One-cycle strobe: result on `crc_o` is final |
| crc_o | output | 16 | Running or final check value |
| hdr_count_i | input | 16 | Entry count for the topology header length |
| hdr_speed_i | input | 1 | 1 selects the speed-map tag as the upper field |
| hdr_word_o | output | 32 | Formed header word |

## Verification
Two pairs of events can land in one cycle. The first is the start pulse and the acceptance of a quadlet. The bench drives both in the same cycle after a partial run has left a non-zero value. It then expects the check value of that single quadlet from zero, which shows the clear won over the stale value and the data was still taken.

The second is the start pulse and the final nibble step that would raise the done strobe. The bench places a start exactly on the eighth cycle of a last quadlet. It then requires no strobe, a zero value and ready high on the next cycle.

// File: rtl/crc16n_pkg.sv
package crc16n_pkg;

    localparam int CRC_W  = 16;
    localparam int NIB_W  = 4;
    localparam int TAP_HI = 12;
    localparam int TAP_LO = 5;

    localparam logic [CRC_W-1:0] SPEED_TAG = 16'h03F1;
    localparam logic [CRC_W-1:0] LEN_BIAS  = 16'd2;

    typedef logic [CRC_W-1:0] crc_t;
    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [1:0] {
        ST_READY,
        ST_SHIFT,
        ST_HOLD
    } feed_state_e;

    typedef struct packed {
        logic clear;
        logic step;
        nib_t nib;
    } feed_cmd_t;

    function automatic crc_t nibble_step(crc_t cur, nib_t nib);
        nib_t s;
        crc_t sx;
        s  = cur[CRC_W-1 -: NIB_W] ^ nib;
        sx = crc_t'(s);
        return crc_t'(cur << NIB_W) ^ crc_t'(sx << TAP_HI) ^ crc_t'(sx << TAP_LO) ^ sx;
    endfunction

endpackage

// File: rtl/crc16n_feeder.sv
module crc16n_feeder
    import crc16n_pkg::*;
#(
    parameter int QUAD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              in_valid_i,
    input  logic [QUAD_W-1:0] in_data_i,
    input  logic              in_last_i,
    output logic              in_ready_o,
    output logic              done_o,
    output feed_cmd_t         cmd_o
);

    localparam int NIBS  = QUAD_W / NIB_W;
    localparam int CNT_W = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NIBS - 1);

    feed_state_e       state_q;
    logic [QUAD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
            shreg_q <= '0;
            cnt_q   <= '0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                state_q <= ST_READY;
                cnt_q   <= '0;
                last_q  <= 1'b0;
                if (in_valid_i && state_q == ST_READY) begin
                    state_q <= ST_SHIFT;
                    shreg_q <= in_data_i;
                    last_q  <= in_last_i;
                end
            end else begin
                case (state_q)
                    ST_READY: begin
                        if (in_valid_i) begin
                            state_q <= ST_SHIFT;
                            shreg_q <= in_data_i;
                            last_q  <= in_last_i;
                            cnt_q   <= '0;
                        end
                    end
                    ST_SHIFT: begin
                        shreg_q <= shreg_q << NIB_W;
                        if (cnt_q == CNT_LAST) begin
                            cnt_q   <= '0;
                            state_q <= last_q ? ST_HOLD : ST_READY;
                            done_q  <= last_q;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        state_q <= ST_HOLD;
                    end
                endcase
            end
        end
    end

    always_comb begin
        in_ready_o  = (state_q == ST_READY);
        done_o      = done_q;
        cmd_o.clear = start_i;
        cmd_o.step  = (state_q == ST_SHIFT) && !start_i;
        cmd_o.nib   = shreg_q[QUAD_W-1 -: NIB_W];
    end

endmodule

// File: rtl/crc16n_accum.sv
module crc16n_accum
    import crc16n_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  feed_cmd_t cmd_i,
    output crc_t      crc_o
);

    crc_t crc_q;

    always_ff @(posedge clk) begin
        if (rst || cmd_i.clear) begin
            crc_q <= '0;
        end else if (cmd_i.step) begin
            crc_q <= nibble_step(crc_q, cmd_i.nib);
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/crc16n_header.sv
module crc16n_header
    import crc16n_pkg::*;
(
    input  crc_t        crc_i,
    input  crc_t        count_i,
    input  logic        speed_i,
    output logic [31:0] word_o
);

    crc_t upper;

    always_comb begin
        upper  = speed_i ? SPEED_TAG : crc_t'(count_i + LEN_BIAS);
        word_o = {upper, crc_i};
    end

endmodule

// File: rtl/crc16n_engine.sv
module crc16n_engine
    import crc16n_pkg::*;
#(
    parameter int QUAD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              in_valid_i,
    input  logic [QUAD_W-1:0] in_data_i,
    input  logic              in_last_i,
    output logic              in_ready_o,
    output logic              done_o,
    output logic [15:0]       crc_o,
    input  logic [15:0]       hdr_count_i,
    input  logic              hdr_speed_i,
    output logic [31:0]       hdr_word_o
);

    feed_cmd_t cmd;
    crc_t      crc_w;

    crc16n_feeder #(.QUAD_W(QUAD_W)) u_feed (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .in_valid_i (in_valid_i),
        .in_data_i  (in_data_i),
        .in_last_i  (in_last_i),
        .in_ready_o (in_ready_o),
        .done_o     (done_o),
        .cmd_o      (cmd)
    );

    crc16n_accum u_acc (
        .clk   (clk),
        .rst   (rst),
        .cmd_i (cmd),
        .crc_o (crc_w)
    );

    crc16n_header u_hdr (
        .crc_i   (crc_w),
        .count_i (hdr_count_i),
        .speed_i (hdr_speed_i),
        .word_o  (hdr_word_o)
    );

    assign crc_o = crc_w;

endmodule

// File: rtl/crc16n_engine_chk.sv
module crc16n_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        in_valid_i,
    input logic        in_ready_o,
    input logic        done_o,
    input logic [15:0] crc_o
);

    assert_ready_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && in_ready_o) |=> !in_ready_o);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_hold_result_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> ($stable(crc_o) && !in_ready_o));

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (crc_o == 16'h0000 && !done_o));

    assert_abort_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (start_i && !in_valid_i) |=> in_ready_o);

endmodule

bind crc16n_engine crc16n_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .done_o     (done_o),
    .crc_o      (crc_o)
);

// File: tb/crc16n_engine_test.sv
module crc16n_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [31:0] in_data_i = '0;
    logic        in_last_i = 1'b0;
    logic        in_ready_o;
    logic        done_o;
    logic [15:0] crc_o;
    logic [15:0] hdr_count_i = '0;
    logic        hdr_speed_i = 1'b0;
    logic [31:0] hdr_word_o;

    int total = 0;
    int fails = 0;
    logic [31:0] seq [8];

    always #4 clk = ~clk;

    crc16n_engine uut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .in_valid_i  (in_valid_i),
        .in_data_i   (in_data_i),
        .in_last_i   (in_last_i),
        .in_ready_o  (in_ready_o),
        .done_o      (done_o),
        .crc_o       (crc_o),
        .hdr_count_i (hdr_count_i),
        .hdr_speed_i (hdr_speed_i),
        .hdr_word_o  (hdr_word_o)
    );

    function automatic logic [15:0] ref_quad(logic [15:0] c, logic [31:0] q);
        logic [31:0] acc;
        logic [31:0] s;
        acc = {16'h0, c};
        for (int sh = 28; sh >= 0; sh -= 4) begin
            s   = ((acc >> 12) ^ (q >> sh)) & 32'hF;
            acc = ((acc << 4) ^ (s << 12) ^ (s << 5) ^ s) & 32'hFFFF;
        end
        return acc[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Drives one quadlet until accepted; returns at the negedge after the accepting edge.
    task automatic accept_quad(input logic [31:0] q, input logic last);
        @(negedge clk);
        in_valid_i = 1'b1;
        in_data_i  = q;
        in_last_i  = last;
        while (!in_ready_o) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
        in_last_i  = 1'b0;
    endtask

    // Counts cycles with ready low after acceptance, stopping on ready or done.
    task automatic send_quad(input logic [31:0] q, input logic last, output int lows);
        accept_quad(q, last);
        lows = 0;
        while (lows < 20 && !in_ready_o && !done_o) begin
            lows++;
            @(negedge clk);
        end
    endtask

    task automatic run_seq(input int n, input int gap);
        logic [15:0] exp;
        int lows;
        exp = 16'h0;
        pulse_start();
        for (int i = 0; i < n; i++) begin
            exp = ref_quad(exp, seq[i]);
            send_quad(seq[i], (i == n - 1), lows);
            chk(lows == 8, "R4 ready low eight cycles", lows, 8);
            if (i != n - 1) begin
                chk(in_ready_o == 1'b1 && done_o == 1'b0, "R4 ready back after non-final", in_ready_o, 1);
                chk(crc_o == exp, "R3 running value", crc_o, exp);
                for (int g = 0; g < gap; g++) @(negedge clk);
            end
        end
        chk(done_o == 1'b1, "R5 done strobe", done_o, 1);
        chk(crc_o == exp, "R3 final value", crc_o, exp);
        @(negedge clk);
        chk(done_o == 1'b0, "R5 done one cycle", done_o, 0);
        chk(crc_o == exp && in_ready_o == 1'b0, "R6 hold", crc_o, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        report();
        $finish;
    end

    initial begin
        logic [15:0] exp;
        int lows;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(crc_o == 16'h0, "R1 crc after reset", crc_o, 0);
        chk(in_ready_o == 1'b1, "R1 ready after reset", in_ready_o, 1);
        chk(done_o == 1'b0, "R1 done after reset", done_o, 0);

        // R2 sweep: every nibble value at every nibble position of one quadlet
        for (int pos = 0; pos < 8; pos++) begin
            for (int v = 0; v < 16; v++) begin
                logic [31:0] q;
                q = 32'(v) << (4 * pos);
                exp = ref_quad(16'h0, q);
                pulse_start();
                send_quad(q, 1'b1, lows);
                chk(lows == 8, "R4 ready low eight cycles", lows, 8);
                chk(done_o == 1'b1, "R5 done after last", done_o, 1);
                chk(crc_o == exp, "R2 single quadlet", crc_o, exp);
                @(negedge clk);
                chk(done_o == 1'b0, "R5 done one cycle", done_o, 0);
                chk(crc_o == exp && in_ready_o == 1'b0, "R6 hold after done", crc_o, exp);
            end
        end

        // R3 multi-quadlet runs, with and without gaps
        seq[0] = 32'h12345678; seq[1] = 32'h9ABCDEF0; seq[2] = 32'hFFFFFFFF; seq[3] = 32'h00000001;
        seq[4] = 32'h807F8C56; seq[5] = 32'hA5A5A5A5; seq[6] = 32'h0000FFFF; seq[7] = 32'hDEADBEEF;
        run_seq(2, 0);
        run_seq(5, 3);
        run_seq(8, 1);

        // R6 longer hold
        repeat (6) @(negedge clk);
        exp = 16'h0;
        for (int i = 0; i < 8; i++) exp = ref_quad(exp, seq[i]);
        chk(crc_o == exp && in_ready_o == 1'b0, "R6 hold many cycles", crc_o, exp);
        in_valid_i = 1'b1; in_data_i = 32'h11111111; in_last_i = 1'b1;
        repeat (4) @(negedge clk);
        in_valid_i = 1'b0; in_last_i = 1'b0;
        chk(crc_o == exp && in_ready_o == 1'b0, "R6 data ignored while holding", crc_o, exp);

        // R7 abort mid-quadlet
        pulse_start();
        accept_quad(32'hCAFEF00D, 1'b1);
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(crc_o == 16'h0, "R7 abort clears", crc_o, 0);
        chk(in_ready_o == 1'b1, "R7 abort ready", in_ready_o, 1);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 12; i++) begin
                if (done_o) seen = 1'b1;
                @(negedge clk);
            end
            chk(!seen, "R7 no done after abort", seen, 0);
        end

        // R7 start on the final nibble cycle of a last quadlet
        pulse_start();
        accept_quad(32'h0BADC0DE, 1'b1);
        repeat (7) @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R7 start beats final nibble done", done_o, 0);
        chk(crc_o == 16'h0 && in_ready_o == 1'b1, "R7 start beats final nibble clear", crc_o, 0);

        // R8 start and data in the same cycle after a partial run
        pulse_start();
        send_quad(32'h76543210, 1'b0, lows);
        chk(crc_o == ref_quad(16'h0, 32'h76543210), "R3 partial before restart", crc_o, ref_quad(16'h0, 32'h76543210));
        @(negedge clk);
        start_i = 1'b1; in_valid_i = 1'b1; in_data_i = 32'hF00DFACE; in_last_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0; in_valid_i = 1'b0; in_last_i = 1'b0;
        chk(in_ready_o == 1'b0, "R8 quadlet taken with start", in_ready_o, 0);
        repeat (8) @(negedge clk);
        exp = ref_quad(16'h0, 32'hF00DFACE);
        chk(done_o == 1'b1, "R8 done for restarted run", done_o, 1);
        chk(crc_o == exp, "R8 value from zero", crc_o, exp);

        // R9 / R10 header former
        hdr_speed_i = 1'b0; hdr_count_i = 16'd5;
        #1;
        chk(hdr_word_o == {16'd7, exp}, "R9 topology header", hdr_word_o, {16'd7, exp});
        hdr_count_i = 16'hFFFF;
        #1;
        chk(hdr_word_o == {16'h0001, exp}, "R9 length wraps", hdr_word_o, {16'h0001, exp});
        hdr_speed_i = 1'b1; hdr_count_i = 16'd40;
        #1;
        chk(hdr_word_o == {16'h03F1, exp}, "R10 speed header", hdr_word_o, {16'h03F1, exp});
        pulse_start();
        chk(hdr_word_o == 32'h03F10000, "R10 speed header after clear", hdr_word_o, 32'h03F10000);

        report();
        $finish;
    end

endmodule